// File: doc/BRIEF.md
# DDR2 Extended Mode Register 1 Controller

This block is the device-side logic of a DDR2-style memory that owns the first extended mode register. It watches the command stream for mode-register loads that target that register, latches the low address bits, and decodes them into the settings the rest of the device uses:

- DLL on or off
- half-strength output drive
- termination selection
- additive latency
- impedance-adjust mode
- single-ended or differential strobing
- read-strobe enable
- output disable

The block also keeps track of whether the DLL has settled. A settling counter restarts whenever the DLL is reset. That happens after a synchronous reset, on exit from self-refresh, and when software turns the DLL back on. A read issued before the count completes, or while the DLL is off, sets a sticky violation flag. The read itself still goes ahead.

For each read, the block produces the registered output enables for the data pins, the strobe, the complementary strobe and the read-strobe pair. It also produces the signal that says whether the data-mask input is active. All of these follow the strobe configuration bits and the output-disable bit.

Top module: `ddr_ext_mode_ctrl`

## Requirements
- R1: After synchronous reset, all decoded fields read zero, so the DLL is enabled. All sticky flags are clear, `dll_ready` is 0 and every output enable is 0.
- R2: A command with code 1 (load mode) and `bank` = 3'b001 updates the register, and the decoded outputs change in the next cycle. A load with any other bank value leaves every decoded output unchanged.
- R3: The field positions are as follows. A1 drives `half_drive`. A5:A3 drive `add_lat`. A9:A7 drive `imp_mode`. A10 drives `single_strobe`. A11 drives `rstrobe_on`. A12 drives `out_off`. `dll_on` is 1 only when A0 is 0 and the device is not in self-refresh.
- R4: The termination code is {A6,A2} and is reported on `term_sel`. The value 2'b11 is reserved: it is reported as 2'b00 and sets the sticky flag `term_rsvd_flag`.
- R5: A load whose address bits 13 and above are not all zero sets the sticky flag `hi_addr_warn`. The decoded fields are the same as for a load of the low 13 bits alone.
- R6: Command code 4 (self-refresh entry) turns the DLL off and drops `dll_ready` in the next cycle. Command code 5 (self-refresh exit) turns the DLL back on and restarts the settling count.
- R7: `dll_ready` rises exactly LOCK_CYCLES (default 200) clock edges after the DLL is reset, whether by reset release, self-refresh exit, or a load that clears A0 while it was 1. A load that sets A0 drops it.
- R8: A read (code 2) while `dll_ready` is 0 sets the sticky flag `early_read_flag`, and the read still drives its output enables. A read after settling leaves the flag clear.
- R9: In the cycle after a read with `out_off` = 0, `oe_dq` and `oe_dqs` are 1, and `oe_dqs_n` is 1 unless `single_strobe` is 1. All enables are 0 in other cycles.
- R10: With X8_PART = 1 and A11 = 1, a read also asserts `oe_rdqs`, and `oe_rdqs_n` as well unless A10 = 1. `dm_active` is then 0. Otherwise `dm_active` is 1 and `oe_rdqs` stays 0.
- R11: A write (code 3) asserts no output enable, including the read-strobe pair.
- R12: With `out_off` = 1, every output enable stays 0, even in the cycle after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code: 0 idle, 1 load mode, 2 read, 3 write, 4 self-refresh entry, 5 self-refresh exit |
| bank | input | BANK_W | Bank address carried with the command |
| addr | input | ADDR_W | Address bits carried with the command |
| dll_on | output | 1 | DLL currently running |
| dll_ready | output | 1 | DLL settling count complete |
| half_drive | output | 1 | Half-strength output drive selected |
| term_sel | output | 2 | Termination code {A6,A2}, reserved value mapped to 0 |
| add_lat | output | 3 | Additive latency field |
| imp_mode | output | 3 | Impedance-adjust mode field |
| single_strobe | output | 1 | Complementary strobes disabled |
| rstrobe_on | output | 1 | Read-strobe enable bit |
| out_off | output | 1 | Outputs disabled |
| dm_active | output | 1 | Data-mask input function active |
| oe_dq | output | 1 | Data output enable |
| oe_dqs | output | 1 | Strobe output enable |
| oe_dqs_n | output | 1 | Complementary strobe output enable |
| oe_rdqs | output | 1 | Read strobe output enable |
| oe_rdqs_n | output | 1 | Complementary read strobe output enable |
| early_read_flag | output | 1 | Sticky: read issued before the DLL settled |
| hi_addr_warn | output | 1 | Sticky: nonzero upper address bits on a load |
| term_rsvd_flag | output | 1 | Sticky: reserved termination code loaded |

## Verification
The bench times the settling window to the edge. It checks `dll_ready` one edge before and exactly at the count after reset release, after self-refresh exit and after re-enable through A0. An off-by-one counter, or one that fails to restart on self-refresh exit, shows up as early or late readiness.

The bench walks all four combinations of the strobe bits, across both reads and writes. A design that decodes the matrix wrongly would drive the complementary strobe in single-ended mode, drive the read strobe during writes, or keep the mask active while the read strobe is on. The bench also covers output disable during reads, the reserved termination code, nonzero upper address bits and loads to other banks. A design that gets any of these wrong leaks enables, reports code 2'b11, changes the fields, or reacts to foreign banks.

// File: rtl/emr_pkg.sv
package emr_pkg;

    typedef enum logic [2:0] {
        CMD_NOP       = 3'd0,
        CMD_LOAD_MODE = 3'd1,
        CMD_READ      = 3'd2,
        CMD_WRITE     = 3'd3,
        CMD_SR_ENTER  = 3'd4,
        CMD_SR_EXIT   = 3'd5
    } cmd_e;

    localparam int          FIELD_W   = 13;
    localparam logic [2:0]  EXT1_BANK = 3'b001;

    // Bit positions inside the stored register
    localparam int POS_DLL    = 0;
    localparam int POS_HALF   = 1;
    localparam int POS_TERM_L = 2;
    localparam int POS_AL_LO  = 3;
    localparam int POS_TERM_H = 6;
    localparam int POS_IMP_LO = 7;
    localparam int POS_SINGLE = 10;
    localparam int POS_RSTRB  = 11;
    localparam int POS_QOFF   = 12;

    typedef struct packed {
        logic       dll_off;
        logic       half_drive;
        logic [1:0] term_sel;
        logic [2:0] add_lat;
        logic [2:0] imp_mode;
        logic       single_strobe;
        logic       rstrobe_req;
        logic       out_off;
    } emr_fields_t;

    function automatic logic term_is_reserved(input logic [FIELD_W-1:0] r);
        return r[POS_TERM_H] & r[POS_TERM_L];
    endfunction

    function automatic emr_fields_t decode_fields(input logic [FIELD_W-1:0] r);
        emr_fields_t f;
        f.dll_off       = r[POS_DLL];
        f.half_drive    = r[POS_HALF];
        f.term_sel      = term_is_reserved(r) ? 2'b00 : {r[POS_TERM_H], r[POS_TERM_L]};
        f.add_lat       = r[POS_AL_LO +: 3];
        f.imp_mode      = r[POS_IMP_LO +: 3];
        f.single_strobe = r[POS_SINGLE];
        f.rstrobe_req   = r[POS_RSTRB];
        f.out_off       = r[POS_QOFF];
        return f;
    endfunction

endpackage

// File: rtl/emr_field_store.sv
module emr_field_store
    import emr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd_c,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    output emr_fields_t       fields,
    output logic              load_now,
    output logic              load_dll_off,
    output logic              hi_addr_warn,
    output logic              term_rsvd_flag
);

    logic [FIELD_W-1:0] reg_q;
    logic               hi_bits_set;

    generate
        if (ADDR_W > FIELD_W) begin : g_hi
            assign hi_bits_set = |addr[ADDR_W-1:FIELD_W];
        end else begin : g_no_hi
            assign hi_bits_set = 1'b0;
        end
    endgenerate

    assign load_now     = (cmd_c == CMD_LOAD_MODE) && (bank == BANK_W'(EXT1_BANK));
    assign load_dll_off = addr[POS_DLL];

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q          <= '0;
            hi_addr_warn   <= 1'b0;
            term_rsvd_flag <= 1'b0;
        end else if (load_now) begin
            reg_q <= addr[FIELD_W-1:0];
            if (hi_bits_set)
                hi_addr_warn <= 1'b1;
            if (term_is_reserved(addr[FIELD_W-1:0]))
                term_rsvd_flag <= 1'b1;
        end
    end

    assign fields = decode_fields(reg_q);

    // R2: loads aimed at another bank leave the register untouched
    a_r2_foreign_bank_ignored: assert property (@(posedge clk) disable iff (rst)
        (cmd_c == CMD_LOAD_MODE && bank != BANK_W'(EXT1_BANK)) |=> $stable(reg_q));

    // R4: reserved termination flag never clears outside reset
    a_r4_term_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        term_rsvd_flag |=> term_rsvd_flag);

    // R4: the reported code never carries the reserved value
    a_r4_no_reserved_code: assert property (@(posedge clk) disable iff (rst)
        fields.term_sel != 2'b11);

    // R5: upper address warning is sticky
    a_r5_warn_sticky: assert property (@(posedge clk) disable iff (rst)
        hi_addr_warn |=> hi_addr_warn);

endmodule

// File: rtl/emr_dll_timer.sv
module emr_dll_timer
    import emr_pkg::*;
#(
    parameter int LOCK_CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  cmd_e cmd_c,
    input  logic dll_off_bit,
    input  logic load_now,
    input  logic load_dll_off,
    output logic dll_on,
    output logic dll_ready,
    output logic early_read_flag
);

    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic             in_sr_q;
    logic             restart;

    assign dll_on    = !dll_off_bit && !in_sr_q;
    assign dll_ready = dll_on && (cnt_q == CNT_MAX);

    assign restart = (cmd_c == CMD_SR_ENTER) || (cmd_c == CMD_SR_EXIT) ||
                     (load_now && (load_dll_off || dll_off_bit));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q           <= '0;
            in_sr_q         <= 1'b0;
            early_read_flag <= 1'b0;
        end else begin
            if (cmd_c == CMD_SR_ENTER)
                in_sr_q <= 1'b1;
            else if (cmd_c == CMD_SR_EXIT)
                in_sr_q <= 1'b0;

            if (restart)
                cnt_q <= '0;
            else if (dll_on && cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;

            if (cmd_c == CMD_READ && !dll_ready)
                early_read_flag <= 1'b1;
        end
    end

    // R6: self-refresh entry removes readiness at once
    a_r6_sr_entry_drops_ready: assert property (@(posedge clk) disable iff (rst)
        (cmd_c == CMD_SR_ENTER) |=> (!dll_ready && !dll_on));

    // R7: readiness only appears after the DLL ran in the previous cycle
    a_r7_ready_after_running: assert property (@(posedge clk) disable iff (rst)
        $rose(dll_ready) |-> $past(dll_on));

    // R7: a load that sets A0 removes readiness
    a_r7_disable_drops_ready: assert property (@(posedge clk) disable iff (rst)
        (load_now && load_dll_off) |=> !dll_ready);

    // R8: premature read is recorded and kept
    a_r8_early_read_set: assert property (@(posedge clk) disable iff (rst)
        (cmd_c == CMD_READ && !dll_ready) |=> early_read_flag);

    a_r8_early_read_sticky: assert property (@(posedge clk) disable iff (rst)
        early_read_flag |=> early_read_flag);

endmodule

// File: rtl/emr_strobe_matrix.sv
module emr_strobe_matrix
    import emr_pkg::*;
#(
    parameter bit X8_PART = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  cmd_e        cmd_c,
    input  emr_fields_t fields,
    output logic        dm_active,
    output logic        oe_dq,
    output logic        oe_dqs,
    output logic        oe_dqs_n,
    output logic        oe_rdqs,
    output logic        oe_rdqs_n
);

    logic rs_live;
    logic drive_rd;

    generate
        if (X8_PART) begin : g_x8
            assign rs_live = fields.rstrobe_req;
        end else begin : g_narrow_wide
            assign rs_live = 1'b0;
        end
    endgenerate

    assign dm_active = !rs_live;
    assign drive_rd  = (cmd_c == CMD_READ) && !fields.out_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_dq     <= 1'b0;
            oe_dqs    <= 1'b0;
            oe_dqs_n  <= 1'b0;
            oe_rdqs   <= 1'b0;
            oe_rdqs_n <= 1'b0;
        end else begin
            oe_dq     <= drive_rd;
            oe_dqs    <= drive_rd;
            oe_dqs_n  <= drive_rd && !fields.single_strobe;
            oe_rdqs   <= drive_rd && rs_live;
            oe_rdqs_n <= drive_rd && rs_live && !fields.single_strobe;
        end
    end

    // R9: an unmasked read drives data and strobe next cycle
    a_r9_read_drives: assert property (@(posedge clk) disable iff (rst)
        (cmd_c == CMD_READ && !fields.out_off) |=> (oe_dq && oe_dqs));

    // R10: the complementary read strobe never runs without the true one
    a_r10_pair_order: assert property (@(posedge clk) disable iff (rst)
        oe_rdqs_n |-> oe_rdqs);

    // R11: a write drives nothing
    a_r11_write_quiet: assert property (@(posedge clk) disable iff (rst)
        (cmd_c == CMD_WRITE) |=> !(oe_dq || oe_dqs || oe_dqs_n || oe_rdqs || oe_rdqs_n));

    // R12: output disable silences every enable
    a_r12_outputs_off: assert property (@(posedge clk) disable iff (rst)
        fields.out_off |=> !(oe_dq || oe_dqs || oe_dqs_n || oe_rdqs || oe_rdqs_n));

endmodule

// File: rtl/ddr_ext_mode_ctrl.sv
module ddr_ext_mode_ctrl
    import emr_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int BANK_W      = 3,
    parameter int LOCK_CYCLES = 200,
    parameter bit X8_PART     = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    output logic              dll_on,
    output logic              dll_ready,
    output logic              half_drive,
    output logic [1:0]        term_sel,
    output logic [2:0]        add_lat,
    output logic [2:0]        imp_mode,
    output logic              single_strobe,
    output logic              rstrobe_on,
    output logic              out_off,
    output logic              dm_active,
    output logic              oe_dq,
    output logic              oe_dqs,
    output logic              oe_dqs_n,
    output logic              oe_rdqs,
    output logic              oe_rdqs_n,
    output logic              early_read_flag,
    output logic              hi_addr_warn,
    output logic              term_rsvd_flag
);

    cmd_e        cmd_c;
    emr_fields_t fields;
    logic        load_now;
    logic        load_dll_off;

    assign cmd_c = cmd_e'(cmd);

    emr_field_store #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_store (
        .clk            (clk),
        .rst            (rst),
        .cmd_c          (cmd_c),
        .bank           (bank),
        .addr           (addr),
        .fields         (fields),
        .load_now       (load_now),
        .load_dll_off   (load_dll_off),
        .hi_addr_warn   (hi_addr_warn),
        .term_rsvd_flag (term_rsvd_flag)
    );

    emr_dll_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
        .clk             (clk),
        .rst             (rst),
        .cmd_c           (cmd_c),
        .dll_off_bit     (fields.dll_off),
        .load_now        (load_now),
        .load_dll_off    (load_dll_off),
        .dll_on          (dll_on),
        .dll_ready       (dll_ready),
        .early_read_flag (early_read_flag)
    );

    emr_strobe_matrix #(.X8_PART(X8_PART)) u_strobe (
        .clk       (clk),
        .rst       (rst),
        .cmd_c     (cmd_c),
        .fields    (fields),
        .dm_active (dm_active),
        .oe_dq     (oe_dq),
        .oe_dqs    (oe_dqs),
        .oe_dqs_n  (oe_dqs_n),
        .oe_rdqs   (oe_rdqs),
        .oe_rdqs_n (oe_rdqs_n)
    );

    assign half_drive    = fields.half_drive;
    assign term_sel      = fields.term_sel;
    assign add_lat       = fields.add_lat;
    assign imp_mode      = fields.imp_mode;
    assign single_strobe = fields.single_strobe;
    assign rstrobe_on    = fields.rstrobe_req;
    assign out_off       = fields.out_off;

    // R1: the cycle after reset shows the cleared state
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!dll_ready && !early_read_flag && !hi_addr_warn && !term_rsvd_flag &&
                 !oe_dq && !out_off));

endmodule

// File: tb/ddr_ext_mode_ctrl_tb.sv
module ddr_ext_mode_ctrl_tb;

    localparam int ADDR_W = 16;
    localparam int BANK_W = 3;
    localparam int LOCK   = 200;

    localparam logic [2:0] C_NOP = 3'd0, C_LOAD = 3'd1, C_READ = 3'd2,
                           C_WRITE = 3'd3, C_SRE = 3'd4, C_SRX = 3'd5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2:0]        cmd = C_NOP;
    logic [BANK_W-1:0] bank = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic dll_on, dll_ready, half_drive, single_strobe, rstrobe_on, out_off, dm_active;
    logic [1:0] term_sel;
    logic [2:0] add_lat, imp_mode;
    logic oe_dq, oe_dqs, oe_dqs_n, oe_rdqs, oe_rdqs_n;
    logic early_read_flag, hi_addr_warn, term_rsvd_flag;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    ddr_ext_mode_ctrl #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .LOCK_CYCLES(LOCK), .X8_PART(1'b1)) u_dut (
        .clk(clk), .rst(rst), .cmd(cmd), .bank(bank), .addr(addr),
        .dll_on(dll_on), .dll_ready(dll_ready), .half_drive(half_drive), .term_sel(term_sel),
        .add_lat(add_lat), .imp_mode(imp_mode), .single_strobe(single_strobe),
        .rstrobe_on(rstrobe_on), .out_off(out_off), .dm_active(dm_active),
        .oe_dq(oe_dq), .oe_dqs(oe_dqs), .oe_dqs_n(oe_dqs_n), .oe_rdqs(oe_rdqs),
        .oe_rdqs_n(oe_rdqs_n), .early_read_flag(early_read_flag),
        .hi_addr_warn(hi_addr_warn), .term_rsvd_flag(term_rsvd_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one command for one edge, return at the following falling edge
    task automatic issue(input logic [2:0] c, input logic [BANK_W-1:0] b, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        cmd = c; bank = b; addr = a;
        @(posedge clk);
        @(negedge clk);
        cmd = C_NOP; bank = '0; addr = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cmd = C_NOP;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [4:0] oe_vec();
        return {oe_dq, oe_dqs, oe_dqs_n, oe_rdqs, oe_rdqs_n};
    endfunction

    task automatic t_reset();
        do_reset();
        chk("R1 fields", {half_drive, term_sel, add_lat, imp_mode, single_strobe, rstrobe_on, out_off}, 0);
        chk("R1 flags", {early_read_flag, hi_addr_warn, term_rsvd_flag}, 0);
        chk("R1 dll_on", dll_on, 1);
        chk("R1 dll_ready", dll_ready, 0);
        chk("R1 enables", oe_vec(), 0);
    endtask

    task automatic t_lock_after_reset();
        do_reset();
        idle(LOCK - 1);
        chk("R7 not ready one edge early", dll_ready, 0);
        idle(1);
        chk("R7 ready at count", dll_ready, 1);
        issue(C_READ, 0, 0);
        chk("R8 settled read leaves flag clear", early_read_flag, 0);
    endtask

    task automatic t_early_read();
        do_reset();
        issue(C_READ, 0, 0);
        chk("R8 early flag set", early_read_flag, 1);
        chk("R8 read still drives", {oe_dq, oe_dqs}, 2'b11);
        idle(3);
        chk("R8 flag sticky", early_read_flag, 1);
    endtask

    task automatic t_fields();
        logic [ADDR_W-1:0] a;
        do_reset();
        // A1=1, A5:A3=3'b101, A9:A7=3'b110, A2=1 -> term 01
        a = 16'h0000 | (16'h1 << 1) | (16'h5 << 3) | (16'h6 << 7) | (16'h1 << 2);
        issue(C_LOAD, 3'b001, a);
        chk("R3 half_drive", half_drive, 1);
        chk("R3 add_lat", add_lat, 3'b101);
        chk("R3 imp_mode", imp_mode, 3'b110);
        chk("R4 term 01", term_sel, 2'b01);
        chk("R4 no flag", term_rsvd_flag, 0);
        issue(C_LOAD, 3'b001, 16'h0040);
        chk("R4 term 10 from A6", term_sel, 2'b10);
        issue(C_LOAD, 3'b010, 16'h0038);
        chk("R2 foreign bank ignored", {add_lat, term_sel}, {3'b000, 2'b10});
        issue(C_LOAD, 3'b000, 16'h0002);
        chk("R2 bank zero ignored", half_drive, 0);
    endtask

    task automatic t_reserved_and_high();
        do_reset();
        issue(C_LOAD, 3'b001, 16'h0044);
        chk("R4 reserved decoded off", term_sel, 2'b00);
        chk("R4 reserved flag", term_rsvd_flag, 1);
        issue(C_LOAD, 3'b001, 16'hA00A);
        chk("R5 warn flag", hi_addr_warn, 1);
        chk("R5 fields from low bits", {half_drive, add_lat, out_off}, {1'b1, 3'b001, 1'b0});
        issue(C_LOAD, 3'b001, 16'h0000);
        chk("R5 warn sticky", hi_addr_warn, 1);
        chk("R4 flag sticky", term_rsvd_flag, 1);
    endtask

    task automatic t_strobe_matrix();
        for (int m = 0; m < 4; m++) begin
            logic s, r;
            s = m[0]; r = m[1];
            do_reset();
            issue(C_LOAD, 3'b001, ({15'b0, r} << 11) | ({15'b0, s} << 10));
            chk("R10 dm_active", dm_active, !r);
            issue(C_READ, 0, 0);
            chk("R9 read enables", {oe_dq, oe_dqs, oe_dqs_n}, {1'b1, 1'b1, !s});
            chk("R10 read strobe pair", {oe_rdqs, oe_rdqs_n}, {r, r && !s});
            idle(1);
            chk("R9 enables drop after read", oe_vec(), 0);
            issue(C_WRITE, 0, 0);
            chk("R11 write drives nothing", oe_vec(), 0);
        end
    endtask

    task automatic t_out_off();
        do_reset();
        issue(C_LOAD, 3'b001, 16'h1800);
        chk("R3 out_off bit", out_off, 1);
        issue(C_READ, 0, 0);
        chk("R12 read silenced", oe_vec(), 0);
    endtask

    task automatic t_self_refresh();
        do_reset();
        idle(LOCK);
        chk("R7 ready before refresh", dll_ready, 1);
        issue(C_SRE, 0, 0);
        chk("R6 dll off in refresh", {dll_on, dll_ready}, 2'b00);
        idle(LOCK + 5);
        chk("R6 stays off in refresh", dll_on, 0);
        issue(C_SRX, 0, 0);
        chk("R6 dll back on", dll_on, 1);
        idle(LOCK - 1);
        chk("R7 exit not ready early", dll_ready, 0);
        idle(1);
        chk("R7 exit ready at count", dll_ready, 1);
    endtask

    task automatic t_dll_bit();
        do_reset();
        idle(LOCK);
        issue(C_LOAD, 3'b001, 16'h0001);
        chk("R3 A0 turns dll off", {dll_on, dll_ready}, 2'b00);
        issue(C_READ, 0, 0);
        chk("R8 read with dll off flagged", early_read_flag, 1);
        issue(C_LOAD, 3'b001, 16'h0000);
        idle(LOCK - 1);
        chk("R7 re-enable not ready early", dll_ready, 0);
        idle(1);
        chk("R7 re-enable ready", dll_ready, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_lock_after_reset();
        t_early_read();
        t_fields();
        t_reserved_and_high();
        t_strobe_matrix();
        t_out_off();
        t_self_refresh();
        t_dll_bit();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule